// File: doc/BRIEF.md
# Class-of-Service Cache Mask Table

This block keeps the cache capacity bitmasks for one socket. Each class of service (COS) has one way-enable mask for the shared last-level cache and one for the second-level cache. A single COS value, taken from the running thread, indexes both tables at once. The two tables may have different depths. A COS that lies past a table's depth gets the fully open all-ones mask for that level only.

Software programs the masks through a configuration port. The block rejects any mask that is not a single contiguous run of ones, and any mask that targets an index past the table. A rejected write leaves the stored value unchanged and sets a sticky error flag. A lookup port returns the two masks one cycle after the COS and access type are presented.

A code/data split mode can be switched on for the last level. The last-level storage is then read as interleaved pairs: a data mask and a code mask for each class. In this mode only the lower half of the COS range is valid.

Top module: `cosMaskTable`

## Requirements
- R1: After reset, every stored entry of both tables holds the all-ones mask ((1 << MASK_LEN) - 1), split mode is off, the error flag is 0, and both lookup outputs are all ones.
- R2: Entry 0 of each table always reads as all ones. A legal write to index 0 is dropped without raising the error flag. While split mode is on, last-level index 1 (the code mask of COS 0) is protected in the same way.
- R3: A write whose data is zero or whose set bits are not one contiguous run is rejected. The old entry is kept, the error flag is set, and no lookup output ever shows such a mask.
- R4: A write to an index at or beyond the selected table's depth (`cfgLevel` 0 = last level with LLC_COS entries, 1 = second level with L2_COS entries) is rejected and sets the error flag. A configuration read of such an index returns all ones.
- R5: The error flag is sticky. It stays set until `errClr` is pulsed. If a new rejection arrives in the same cycle as `errClr`, the flag stays set.
- R6: With split mode off, `llcMask` is last-level entry `cosIn` when `cosIn` < LLC_COS, and all ones otherwise. `isCode` has no effect in this mode.
- R7: `l2Mask` is second-level entry `cosIn` when `cosIn` < L2_COS, and all ones otherwise. This holds whatever the last-level result is and whatever the split mode setting is.
- R8: With split mode on, a data access (`isCode` = 0) uses last-level entry 2*cosIn and a code access (`isCode` = 1) uses entry 2*cosIn+1 when `cosIn` < LLC_COS/2. Otherwise `llcMask` is all ones.
- R9: A `splitWrEn` pulse whose `splitVal` differs from the current mode switches the mode and reloads every last-level entry with all ones. A pulse that repeats the current mode changes nothing. The second-level table is never reloaded.
- R10: The lookup outputs are registered and appear on the clock edge after `cosIn` and `isCode` are sampled. A write accepted at a clock edge is seen by lookups sampled at the next edge, not by the lookup sampled at the same edge.
- R11: `cfgRdData` shows, with no clock delay, the stored entry at `cfgIdx` of the table chosen by `cfgLevel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for one mask entry |
| cfgLevel | input | 1 | Table select: 0 last level, 1 second level |
| cfgIdx | input | COS_W | Physical entry index for write and read |
| cfgWrData | input | MASK_LEN | Mask to write |
| cfgRdData | output | MASK_LEN | Entry at cfgIdx, or all ones when out of range |
| splitWrEn | input | 1 | Strobe to load the split mode setting |
| splitVal | input | 1 | New split mode value (1 = code/data split) |
| errClr | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky flag for rejected writes |
| cosIn | input | COS_W | Class of service of the running thread |
| isCode | input | 1 | Access type: 1 code fetch, 0 data fetch |
| llcMask | output | MASK_LEN | Last-level way-enable mask, registered |
| l2Mask | output | MASK_LEN | Second-level way-enable mask, registered |

## Verification
The lookup is driven with COS values below both depths, between the second-level and last-level depths, and above both. These cases show per-level fallback apart from a shared one. Both access types are sent with split mode off and on, so a design that ignores `isCode` in split mode, or uses it when split mode is off, shows a wrong mask. Writes use contiguous, holed, zero, protected-index and out-of-range data, which separates rejection with error from silent drop. A long random phase mixes all of these, including mode toggles, against a behavioural model.

// File: rtl/cosMaskPkg.sv
package cosMaskPkg;

  typedef enum logic {
    LVL_LAST = 1'b0,
    LVL_MID  = 1'b1
  } cacheLvl_e;

  // strobes from the control module to the table datapath
  typedef struct packed {
    logic llcWr;
    logic l2Wr;
    logic reloadLlc;
    logic setErr;
  } maskStrobe_t;

endpackage

// File: rtl/cosMaskCtrl.sv
module cosMaskCtrl
  import cosMaskPkg::*;
#(
  parameter int MASK_LEN = 8,
  parameter int LLC_COS  = 16,
  parameter int L2_COS   = 8,
  parameter int COS_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  cacheLvl_e           cfgLevel,
  input  logic [COS_W-1:0]    cfgIdx,
  input  logic [MASK_LEN-1:0] cfgWrData,
  input  logic                splitWrEn,
  input  logic                splitVal,
  input  logic                errClr,
  output maskStrobe_t         strobe,
  output logic                splitMode,
  output logic                errFlag
);

  localparam logic [COS_W-1:0] LLC_LIM = COS_W'(LLC_COS);
  localparam logic [COS_W-1:0] L2_LIM  = COS_W'(L2_COS);

  logic [MASK_LEN-1:0] lowBit;
  logic [MASK_LEN-1:0] carrySum;
  logic                maskLegal;
  logic                idxInRange;
  logic                idxLocked;
  logic                wrAccept;

  // a single run of ones: adding its lowest bit clears the whole run
  assign lowBit    = cfgWrData & (~cfgWrData + MASK_LEN'(1));
  assign carrySum  = cfgWrData + lowBit;
  assign maskLegal = (cfgWrData != '0) && ((carrySum & cfgWrData) == '0);

  assign idxInRange = (cfgLevel == LVL_MID) ? (cfgIdx < L2_LIM) : (cfgIdx < LLC_LIM);
  assign idxLocked  = (cfgIdx == '0) ||
                      ((cfgLevel == LVL_LAST) && splitMode && (cfgIdx == COS_W'(1)));
  assign wrAccept   = cfgWrEn && idxInRange && maskLegal && !idxLocked;

  always_comb begin
    strobe.setErr    = cfgWrEn && (!idxInRange || !maskLegal);
    strobe.reloadLlc = splitWrEn && (splitVal != splitMode);
    strobe.llcWr     = wrAccept && (cfgLevel == LVL_LAST) && !strobe.reloadLlc;
    strobe.l2Wr      = wrAccept && (cfgLevel == LVL_MID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      splitMode <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (splitWrEn) splitMode <= splitVal;
      if (strobe.setErr)  errFlag <= 1'b1;
      else if (errClr)    errFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/cosMaskData.sv
module cosMaskData
  import cosMaskPkg::*;
#(
  parameter int MASK_LEN = 8,
  parameter int LLC_COS  = 16,
  parameter int L2_COS   = 8,
  parameter int COS_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  maskStrobe_t         strobe,
  input  logic                splitMode,
  input  cacheLvl_e           cfgLevel,
  input  logic [COS_W-1:0]    cfgIdx,
  input  logic [MASK_LEN-1:0] cfgWrData,
  output logic [MASK_LEN-1:0] cfgRdData,
  input  logic [COS_W-1:0]    cosIn,
  input  logic                isCode,
  output logic [MASK_LEN-1:0] llcMask,
  output logic [MASK_LEN-1:0] l2Mask
);

  localparam int LLC_IW = $clog2(LLC_COS);
  localparam int L2_IW  = $clog2(L2_COS);
  localparam logic [MASK_LEN-1:0] ALL_ONES = {MASK_LEN{1'b1}};
  localparam logic [COS_W-1:0] LLC_LIM  = COS_W'(LLC_COS);
  localparam logic [COS_W-1:0] L2_LIM   = COS_W'(L2_COS);
  localparam logic [COS_W-1:0] HALF_LIM = COS_W'(LLC_COS / 2);

  logic [MASK_LEN-1:0] llcTab [LLC_COS];
  logic [MASK_LEN-1:0] l2Tab  [L2_COS];

  genvar e;
  generate
    for (e = 0; e < LLC_COS; e++) begin : g_llcEntry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                       llcTab[e] <= ALL_ONES;
        else if (strobe.reloadLlc)                       llcTab[e] <= ALL_ONES;
        else if (strobe.llcWr && cfgIdx == COS_W'(e))    llcTab[e] <= cfgWrData;
      end
    end
    for (e = 0; e < L2_COS; e++) begin : g_l2Entry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                       l2Tab[e] <= ALL_ONES;
        else if (strobe.l2Wr && cfgIdx == COS_W'(e))     l2Tab[e] <= cfgWrData;
      end
    end
  endgenerate

  logic [COS_W-1:0]    pairIdx;
  logic [MASK_LEN-1:0] llcNext;
  logic [MASK_LEN-1:0] l2Next;

  assign pairIdx = {cosIn[COS_W-2:0], isCode};

  always_comb begin
    if (splitMode)
      llcNext = (cosIn < HALF_LIM) ? llcTab[pairIdx[LLC_IW-1:0]] : ALL_ONES;
    else
      llcNext = (cosIn < LLC_LIM) ? llcTab[cosIn[LLC_IW-1:0]] : ALL_ONES;
    l2Next = (cosIn < L2_LIM) ? l2Tab[cosIn[L2_IW-1:0]] : ALL_ONES;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      llcMask <= ALL_ONES;
      l2Mask  <= ALL_ONES;
    end else begin
      llcMask <= llcNext;
      l2Mask  <= l2Next;
    end
  end

  always_comb begin
    if (cfgLevel == LVL_MID)
      cfgRdData = (cfgIdx < L2_LIM) ? l2Tab[cfgIdx[L2_IW-1:0]] : ALL_ONES;
    else
      cfgRdData = (cfgIdx < LLC_LIM) ? llcTab[cfgIdx[LLC_IW-1:0]] : ALL_ONES;
  end

endmodule

// File: rtl/cosMaskTable.sv
module cosMaskTable
  import cosMaskPkg::*;
#(
  parameter int MASK_LEN = 8,
  parameter int LLC_COS  = 16,
  parameter int L2_COS   = 8,
  parameter int COS_W    = $clog2((LLC_COS > L2_COS) ? LLC_COS : L2_COS) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgLevel,
  input  logic [COS_W-1:0]    cfgIdx,
  input  logic [MASK_LEN-1:0] cfgWrData,
  output logic [MASK_LEN-1:0] cfgRdData,
  input  logic                splitWrEn,
  input  logic                splitVal,
  input  logic                errClr,
  output logic                errFlag,
  input  logic [COS_W-1:0]    cosIn,
  input  logic                isCode,
  output logic [MASK_LEN-1:0] llcMask,
  output logic [MASK_LEN-1:0] l2Mask
);

  maskStrobe_t strobe;
  logic        splitMode;
  cacheLvl_e   lvlSel;

  assign lvlSel = cacheLvl_e'(cfgLevel);

  cosMaskCtrl #(
    .MASK_LEN(MASK_LEN), .LLC_COS(LLC_COS), .L2_COS(L2_COS), .COS_W(COS_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLevel(lvlSel),
    .cfgIdx(cfgIdx), .cfgWrData(cfgWrData), .splitWrEn(splitWrEn),
    .splitVal(splitVal), .errClr(errClr), .strobe(strobe),
    .splitMode(splitMode), .errFlag(errFlag)
  );

  cosMaskData #(
    .MASK_LEN(MASK_LEN), .LLC_COS(LLC_COS), .L2_COS(L2_COS), .COS_W(COS_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .splitMode(splitMode),
    .cfgLevel(lvlSel), .cfgIdx(cfgIdx), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cosIn(cosIn), .isCode(isCode),
    .llcMask(llcMask), .l2Mask(l2Mask)
  );

endmodule

// File: rtl/cosMaskTableChk.sv
module cosMaskTableChk #(
  parameter int MASK_LEN = 8,
  parameter int LLC_COS  = 16,
  parameter int L2_COS   = 8,
  parameter int COS_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic                cfgLevel,
  input logic [COS_W-1:0]    cfgIdx,
  input logic [MASK_LEN-1:0] cfgRdData,
  input logic                errClr,
  input logic                errFlag,
  input logic                splitMode,
  input logic [COS_W-1:0]    cosIn,
  input logic [MASK_LEN-1:0] llcMask,
  input logic [MASK_LEN-1:0] l2Mask
);

  localparam logic [MASK_LEN-1:0] ALL_ONES = {MASK_LEN{1'b1}};

  function automatic logic oneRun(logic [MASK_LEN-1:0] m);
    logic [MASK_LEN-1:0] low;
    low = m & (~m + MASK_LEN'(1));
    return (m != '0) && (((m + low) & m) == '0);
  endfunction

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !cfgWrEn) |=> !errFlag);

  p_entry0_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIdx == '0) |-> (cfgRdData == ALL_ONES));

  p_l2_fallback_r7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cosIn) >= L2_COS) |=> (l2Mask == ALL_ONES));

  p_llc_fallback_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cosIn) >= LLC_COS) |=> (llcMask == ALL_ONES));

  p_split_half_r8: assert property (@(posedge clk) disable iff (!rstN)
    (splitMode && int'(cosIn) >= LLC_COS / 2) |=> (llcMask == ALL_ONES));

  p_legal_out_r3: assert property (@(posedge clk) disable iff (!rstN)
    oneRun(llcMask) && oneRun(l2Mask));

  p_oob_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLevel && int'(cfgIdx) >= L2_COS) |-> (cfgRdData == ALL_ONES));

endmodule

bind cosMaskTable cosMaskTableChk #(
  .MASK_LEN(MASK_LEN), .LLC_COS(LLC_COS), .L2_COS(L2_COS), .COS_W(COS_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLevel(cfgLevel),
  .cfgIdx(cfgIdx), .cfgRdData(cfgRdData), .errClr(errClr),
  .errFlag(errFlag), .splitMode(splitMode), .cosIn(cosIn),
  .llcMask(llcMask), .l2Mask(l2Mask)
);

// File: tb/cosMaskTable_tb_top.sv
`timescale 1ns/1ps
module cosMaskTable_tb_top;

  localparam int ML = 8;
  localparam int NLLC = 16;
  localparam int NL2 = 8;
  localparam int CW = 5;
  localparam int ONES = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic cfgLevel = 1'b0;
  logic [CW-1:0] cfgIdx = '0;
  logic [ML-1:0] cfgWrData = '0;
  logic [ML-1:0] cfgRdData;
  logic splitWrEn = 1'b0;
  logic splitVal = 1'b0;
  logic errClr = 1'b0;
  logic errFlag;
  logic [CW-1:0] cosIn = '0;
  logic isCode = 1'b0;
  logic [ML-1:0] llcMask;
  logic [ML-1:0] l2Mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cosMaskTable dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLevel(cfgLevel),
    .cfgIdx(cfgIdx), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .splitWrEn(splitWrEn), .splitVal(splitVal), .errClr(errClr),
    .errFlag(errFlag), .cosIn(cosIn), .isCode(isCode),
    .llcMask(llcMask), .l2Mask(l2Mask)
  );

  // behavioural reference model
  int mLlc[NLLC];
  int mL2[NL2];
  bit mSplit, mErr;
  int expLlc = ONES, expL2 = ONES;

  function automatic bit legalMask(int m);
    int runs = 0;
    for (int b = 0; b < ML; b++)
      if (m[b] && (b == 0 || !m[b-1])) runs++;
    return runs == 1;
  endfunction

  function automatic int rdModel(bit lvl, int idx);
    if (lvl) return (idx < NL2) ? mL2[idx] : ONES;
    return (idx < NLLC) ? mLlc[idx] : ONES;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mLlc[i]) mLlc[i] = ONES;
      foreach (mL2[i]) mL2[i] = ONES;
      mSplit = 0; mErr = 0; expLlc = ONES; expL2 = ONES;
    end else begin
      int c, idx, depth;
      bit tog, errSet;
      c = int'(cosIn); idx = int'(cfgIdx);
      if (mSplit) expLlc = (c < NLLC/2) ? mLlc[2*c + int'(isCode)] : ONES;
      else        expLlc = (c < NLLC) ? mLlc[c] : ONES;
      expL2 = (c < NL2) ? mL2[c] : ONES;
      tog = splitWrEn && (splitVal != mSplit);
      errSet = 0;
      if (cfgWrEn) begin
        depth = cfgLevel ? NL2 : NLLC;
        if (idx >= depth || !legalMask(int'(cfgWrData))) errSet = 1;
        else if (!(idx == 0 || (!cfgLevel && mSplit && idx == 1))) begin
          if (cfgLevel) mL2[idx] = int'(cfgWrData);
          else if (!tog) mLlc[idx] = int'(cfgWrData);
        end
      end
      if (tog) foreach (mLlc[i]) mLlc[i] = ONES;
      if (splitWrEn) mSplit = splitVal;
      if (errSet) mErr = 1; else if (errClr) mErr = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R6/R8 llcMask", int'(llcMask), expLlc);
      chk("R7 l2Mask", int'(l2Mask), expL2);
      chk("R5 errFlag", int'(errFlag), int'(mErr));
      chk("R11 cfgRdData", int'(cfgRdData), rdModel(cfgLevel, int'(cfgIdx)));
    end
  end

  task automatic wr(bit lvl, int idx, int data);
    @(posedge clk); #1;
    cfgWrEn = 1; cfgLevel = lvl; cfgIdx = CW'(idx); cfgWrData = ML'(data);
    @(posedge clk); #1;
    cfgWrEn = 0;
  endtask

  task automatic rd(bit lvl, int idx);
    @(posedge clk); #1;
    cfgLevel = lvl; cfgIdx = CW'(idx);
    @(negedge clk);
  endtask

  task automatic look(int c, bit code);
    @(posedge clk); #1;
    cosIn = CW'(c); isCode = code;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setSplit(bit v);
    @(posedge clk); #1;
    splitWrEn = 1; splitVal = v;
    @(posedge clk); #1;
    splitWrEn = 0;
  endtask

  task automatic clearErr();
    @(posedge clk); #1; errClr = 1;
    @(posedge clk); #1; errClr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 llcMask reset", int'(llcMask), ONES);
    chk("R1 l2Mask reset", int'(l2Mask), ONES);
    chk("R1 errFlag reset", int'(errFlag), 0);
    rd(0, 5);
    chk("R1 llc entry reset", int'(cfgRdData), ONES);

    // R2 entry 0 protected, no error
    wr(0, 0, 8'h0F);
    rd(0, 0);
    chk("R2 llc entry0", int'(cfgRdData), ONES);
    chk("R2 no error", int'(errFlag), 0);
    wr(1, 0, 8'h03);
    rd(1, 0);
    chk("R2 l2 entry0", int'(cfgRdData), ONES);

    // R10 write and lookup in the same cycle
    @(posedge clk); #1;
    cfgWrEn = 1; cfgLevel = 0; cfgIdx = 3; cfgWrData = 8'h3C; cosIn = 3; isCode = 0;
    @(posedge clk); #1; cfgWrEn = 0;
    @(negedge clk);
    chk("R10 old value at write edge", int'(llcMask), ONES);
    @(posedge clk); @(negedge clk);
    chk("R10 new value next edge", int'(llcMask), 8'h3C);

    // R3 illegal masks
    wr(0, 3, 8'h5A);
    rd(0, 3);
    chk("R3 holed mask kept old", int'(cfgRdData), 8'h3C);
    chk("R3 error set", int'(errFlag), 1);
    clearErr();
    @(negedge clk);
    chk("R5 cleared", int'(errFlag), 0);
    wr(0, 4, 0);
    rd(0, 4);
    chk("R3 zero rejected", int'(cfgRdData), ONES);
    chk("R3 zero sets error", int'(errFlag), 1);
    // R5 rejection in same cycle as clear keeps flag
    @(posedge clk); #1;
    cfgWrEn = 1; cfgLevel = 0; cfgIdx = 4; cfgWrData = 8'h81; errClr = 1;
    @(posedge clk); #1; cfgWrEn = 0; errClr = 0;
    @(negedge clk);
    chk("R5 set wins over clear", int'(errFlag), 1);
    clearErr();

    // R4 out of range
    wr(1, 9, 8'h03);
    @(negedge clk);
    chk("R4 oob write error", int'(errFlag), 1);
    rd(1, 9);
    chk("R4 oob read", int'(cfgRdData), ONES);
    clearErr();

    // R6 / R7 per-level fallback
    wr(1, 5, 8'h03);
    wr(0, 12, 8'hF0);
    look(5, 0);
    chk("R7 l2 stored", int'(l2Mask), 8'h03);
    look(12, 0);
    chk("R6 llc stored", int'(llcMask), 8'hF0);
    chk("R7 l2 beyond depth", int'(l2Mask), ONES);
    look(20, 0);
    chk("R6 llc beyond depth", int'(llcMask), ONES);
    look(3, 1);
    chk("R6 isCode ignored", int'(llcMask), 8'h3C);

    // R9 / R8 split mode
    setSplit(1);
    rd(0, 3);
    chk("R9 reload on enable", int'(cfgRdData), ONES);
    wr(0, 6, 8'h0F);
    wr(0, 7, 8'hC0);
    look(3, 0);
    chk("R8 data entry", int'(llcMask), 8'h0F);
    look(3, 1);
    chk("R8 code entry", int'(llcMask), 8'hC0);
    look(9, 0);
    chk("R8 beyond half", int'(llcMask), ONES);
    chk("R7 l2 in split", int'(l2Mask), ONES);
    wr(0, 1, 8'h03);
    rd(0, 1);
    chk("R2 cos0 code protected", int'(cfgRdData), ONES);
    chk("R2 no error in split", int'(errFlag), 0);
    setSplit(1);
    rd(0, 6);
    chk("R9 same value no reload", int'(cfgRdData), 8'h0F);
    setSplit(0);
    rd(0, 6);
    chk("R9 reload on disable", int'(cfgRdData), ONES);
    rd(1, 5);
    chk("R9 l2 untouched", int'(cfgRdData), 8'h03);

    // mixed random traffic checked by the model each cycle
    for (int n = 0; n < 3000; n++) begin
      int kind, lo, len;
      @(posedge clk); #1;
      kind = $urandom_range(0, 19);
      cfgWrEn = (kind < 8);
      cfgLevel = $urandom_range(0, 1);
      cfgIdx = CW'($urandom_range(0, 31));
      lo = $urandom_range(0, 7); len = $urandom_range(1, 8 - lo);
      cfgWrData = (kind < 6) ? ML'(((1 << len) - 1) << lo) : ML'($urandom_range(0, 255));
      splitWrEn = (kind == 8);
      splitVal = $urandom_range(0, 1);
      errClr = (kind == 9);
      cosIn = CW'($urandom_range(0, 31));
      isCode = $urandom_range(0, 1);
    end
    @(posedge clk); #1;
    cfgWrEn = 0; splitWrEn = 0; errClr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule